// File: doc/BRIEF.md
# Block-Scaled FP8 Quantizer

This block converts a stream of 16-bit floating-point values into 8-bit E4M3 codes that share one power-of-two scale per group of 32. A parameter selects the input format: half precision (5 exponent bits, 10 mantissa bits) or bfloat16 (8 exponent bits, 7 mantissa bits). Input arrives as valid/ready beats of eight lanes, so four consecutive beats form one group.

While the beats of a group arrive, the block keeps a running maximum of the element magnitudes, ignoring NaN. Once the fourth beat is in, it derives an exponent-only scale byte from that maximum. It multiplies every element by the reciprocal of the scale, which is an exact power of two, and rounds the result to E4M3. Values out of range saturate to the largest finite magnitude. Each group leaves as one wide output word of 32 codes together with its scale byte, under a valid/ready handshake of its own.

Top module: `mxfp8_quantizer`

## Requirements
- R1: Lane i of beat b (0-based, lane i at in_data bits 16i+15:16i) is element 8b+i of a group. Its code appears at out_codes bits 8j+7:8j with j = 8b+i. out_valid rises no earlier than the clock edge after the one that accepts the fourth beat, and it rises exactly there when the output register is free.
- R2: The scale byte is 127 + ceil(log2(amax/448)), where amax is the largest element magnitude. The byte encodes 2^(byte-127), is clamped to 0..254, and is never 255.
- R3: amax ignores the sign and skips NaN elements. An infinite element counts as the largest magnitude and gives scale byte 254.
- R4: Each element is multiplied by 2^(127-scale) and encoded as E4M3 with round-to-nearest-even. The code has the sign in bit 7, the exponent (bias 7) in bits 6:3 and the mantissa in bits 2:0.
- R5: Scaled magnitudes below 2^-6 are encoded with exponent field 0 as m/8·2^-6. Rounding may carry up into the smallest normal code 0x08.
- R6: Scaled magnitudes above 448 after rounding, including infinite inputs, give 0x7E, or 0xFE when negative.
- R7: A NaN element gives 0x7F, or 0xFF when its sign bit is set.
- R8: A zero element of either sign gives code 0x00. A group with no nonzero, non-NaN element gets scale byte 0.
- R9: While out_valid is high and out_ready is low, out_codes and out_scale hold their values. The block holds at most one complete group besides the one on its output, and in_ready is low while both are occupied and out_ready is low.
- R10: Reset clears out_valid, raises in_ready and restarts beat counting, so a partial group is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat is present |
| in_ready | output | 1 | Block accepts a beat this cycle |
| in_data | input | LANES*16 | Eight 16-bit elements, lane 0 in the low bits |
| out_valid | output | 1 | A quantized group is on the outputs |
| out_ready | input | 1 | Consumer takes the group this cycle |
| out_codes | output | LANES*BEATS*8 | 32 E4M3 codes, element 0 in the low byte |
| out_scale | output | 8 | Exponent-only scale byte of the group |

## Verification
A group's codes and scale become visible one clock after the edge that accepts its fourth beat, provided the output register is free. If it is not free, they appear one clock after the handshake that empties it. The bench drives and samples on the falling edge. It checks that out_valid is still low half a cycle after the last beat is accepted and high one full cycle later. In the stalled case it reads in_ready right after the second group completes, and it checks the held outputs over several stalled cycles before it releases them.

// File: rtl/mxfp8_quantizer.sv
module mxfp8_quantizer #(
  parameter bit IN_BF16 = 1'b0,
  parameter int LANES   = 8,
  parameter int BEATS   = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [LANES*16-1:0]      in_data,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [LANES*BEATS*8-1:0] out_codes,
  output logic [7:0]               out_scale
);
  localparam int BLK  = LANES * BEATS;
  localparam int MW   = IN_BF16 ? 7 : 10;
  localparam int EW   = 15 - MW;
  localparam int BIAS = (1 << (EW - 1)) - 1;
  localparam int CW   = BEATS > 1 ? $clog2(BEATS) : 1;

  function automatic logic is_nan(input logic [15:0] x);
    return (&x[14:MW]) && (|x[MW-1:0]);
  endfunction

  function automatic void unpack(input logic [14:0] m, output int e, output int sig);
    int p;
    p = 0;
    if (m[14:MW] != '0) begin
      e   = int'(m[14:MW]) - BIAS;
      sig = int'({1'b1, m[MW-1:0]});
    end else begin
      for (int i = 0; i < MW; i++) if (m[i]) p = i;
      e   = p + 1 - BIAS - MW;
      sig = int'(m[MW-1:0]) << (MW - p);
    end
  endfunction

  function automatic logic [7:0] scale_of(input logic [14:0] m);
    int e, sig, x;
    if (m == '0) return 8'd0;
    if (&m[14:MW]) return 8'd254;
    unpack(m, e, sig);
    x = e - 8 + 127 + (((sig & ((1 << MW) - 1)) > (3 << (MW - 2))) ? 1 : 0);
    if (x < 0) x = 0;
    if (x > 254) x = 254;
    return 8'(x);
  endfunction

  function automatic logic [7:0] encode(input logic [15:0] x, input logic [7:0] sb);
    int e, sig, ey, sh, kept, rem, half, up, f;
    if (is_nan(x)) return {x[15], 7'h7F};
    if (x[14:0] == '0) return 8'h00;
    if (&x[14:MW]) return {x[15], 7'h7E};
    unpack(x[14:0], e, sig);
    ey = e - (int'(sb) - 127);
    if (ey > 8) return {x[15], 7'h7E};
    sh = (ey >= -6) ? MW - 3 : MW - 3 + (-6 - ey);
    if (sh > MW + 1) return {x[15], 7'h00};
    kept = sig >> sh;
    rem  = sig & ((1 << sh) - 1);
    half = 1 << (sh - 1);
    up   = (rem > half || (rem == half && (kept & 1) == 1)) ? 1 : 0;
    f    = (ey >= -6) ? ((((ey + 7) << 3) | (kept & 7)) + up) : (kept + up);
    if (f > 126) f = 126;
    return {x[15], 7'(f)};
  endfunction

  logic [CW-1:0] beat;
  logic [15:0]   raw [BLK];
  logic [14:0]   amax, beat_max;
  logic          full, acc, load;
  logic [7:0]    blk_scale;
  logic [BLK*8-1:0] codes;

  assign load      = full && (!out_valid || out_ready);
  assign in_ready  = !full || !out_valid || out_ready;
  assign acc       = in_valid && in_ready;
  assign blk_scale = scale_of(amax);

  always_comb begin
    beat_max = (beat == '0) ? '0 : amax;
    for (int i = 0; i < LANES; i++)
      if (!is_nan(in_data[16*i +: 16]) && in_data[16*i +: 15] > beat_max)
        beat_max = in_data[16*i +: 15];
  end

  always_comb
    for (int j = 0; j < BLK; j++) codes[8*j +: 8] = encode(raw[j], blk_scale);

  always_ff @(posedge clk)
    if (acc)
      for (int l = 0; l < LANES; l++) raw[int'(beat) * LANES + l] <= in_data[16*l +: 16];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      beat      <= '0;
      amax      <= '0;
      full      <= 1'b0;
      out_valid <= 1'b0;
      out_codes <= '0;
      out_scale <= '0;
    end else begin
      if (acc) begin
        amax <= beat_max;
        beat <= (beat == CW'(BEATS - 1)) ? '0 : beat + 1'b1;
      end
      if (acc && beat == CW'(BEATS - 1)) full <= 1'b1;
      else if (load) full <= 1'b0;
      if (load) begin
        out_valid <= 1'b1;
        out_codes <= codes;
        out_scale <= blk_scale;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
endmodule

// File: rtl/mxfp8_quantizer_chk.sv
module mxfp8_quantizer_chk #(
  parameter int BEATS = 4,
  parameter int OW    = 256
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [OW-1:0] out_codes,
  input logic [7:0]    out_scale
);
  int bc, pend;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bc   <= 0;
      pend <= 0;
    end else begin
      pend <= pend + ((in_valid && in_ready && bc == BEATS - 1) ? 1 : 0)
                   - ((out_valid && out_ready) ? 1 : 0);
      if (in_valid && in_ready) bc <= (bc == BEATS - 1) ? 0 : bc + 1;
    end

  p_no_early_out_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> pend >= 1);
  p_scale_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_scale != 8'hFF);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_codes) && $stable(out_scale));
  p_two_groups_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pend <= 2);
  p_full_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pend == 2 && !out_ready |-> !in_ready);
  p_reset_r10: assert property (@(posedge clk)
    !rst_n |=> !out_valid);
endmodule

bind mxfp8_quantizer mxfp8_quantizer_chk #(.BEATS(BEATS), .OW(LANES*BEATS*8)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_codes(out_codes), .out_scale(out_scale)
);

// File: tb/mxfp8_quantizer_test.sv
`timescale 1ns/1ps
module mxfp8_quantizer_test;
  logic clk = 0, rst_n = 0, in_valid = 0, in_ready, out_valid, out_ready = 0;
  logic [127:0] in_data = '0;
  logic [255:0] out_codes;
  logic [7:0]   out_scale;
  int checks = 0, errors = 0, cyc = 0;

  always #2.5 clk = ~clk;

  mxfp8_quantizer uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_codes(out_codes), .out_scale(out_scale)
  );

  // x, amax, amax position, scale, code of x (element 13), code of amax element
  localparam logic [63:0] VEC [15] = '{
    {16'h3C00, 16'h5F00, 8'd0,  8'h7F, 8'h38, 8'h7E},
    {16'hB800, 16'h3C00, 8'd31, 8'h77, 8'hF0, 8'h78},
    {16'hDF00, 16'h5F01, 8'd5,  8'h80, 8'hF6, 8'h76},
    {16'h1800, 16'h5F00, 8'd0,  8'h7F, 8'h01, 8'h7E},
    {16'h1400, 16'h5F00, 8'd0,  8'h7F, 8'h00, 8'h7E},
    {16'h1600, 16'h5F00, 8'd0,  8'h7F, 8'h01, 8'h7E},
    {16'h2380, 16'h5F00, 8'd0,  8'h7F, 8'h08, 8'h7E},
    {16'h3C40, 16'h5F00, 8'd0,  8'h7F, 8'h38, 8'h7E},
    {16'h3CC0, 16'h5F00, 8'd0,  8'h7F, 8'h3A, 8'h7E},
    {16'h7E00, 16'h3C00, 8'd0,  8'h77, 8'h7F, 8'h78},
    {16'hFE00, 16'h3C00, 8'd0,  8'h77, 8'hFF, 8'h78},
    {16'hFC00, 16'h7C00, 8'd0,  8'hFE, 8'hFE, 8'h7E},
    {16'h8001, 16'h0001, 8'd0,  8'h5F, 8'hF8, 8'h78},
    {16'h8000, 16'h0000, 8'd0,  8'h00, 8'h00, 8'h00},
    {16'h3800, 16'hBC00, 8'd20, 8'h77, 8'h70, 8'hF8}
  };
  localparam string VTAG [15] = '{"R4", "R2", "R2", "R5", "R5", "R5", "R5", "R4", "R4",
                                  "R7", "R7", "R6", "R3", "R8", "R3"};

  logic [15:0]  blk [32];
  logic [255:0] got;
  logic [7:0]   gsc;

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send_beat(input logic [127:0] d);
    in_valid = 1'b1;
    in_data  = d;
    #0.1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_block();
    for (int b = 0; b < 4; b++) begin
      logic [127:0] d;
      for (int l = 0; l < 8; l++) d[16*l +: 16] = blk[b*8 + l];
      send_beat(d);
    end
  endtask

  task automatic get_block();
    out_ready = 1'b1;
    #0.1;
    while (!out_valid) @(negedge clk);
    got = out_codes;
    gsc = out_scale;
    @(negedge clk);
  endtask

  function automatic logic [7:0] pat_code(input int j, input bit hi_neg);
    logic s;
    s = hi_neg ? (j >= 16) : (j < 16);
    return {s, (j % 16 == 0) ? 7'h04 : {4'(j % 16), 3'b000}};
  endfunction

  task automatic fill_pattern(input bit hi_neg);
    for (int j = 0; j < 32; j++)
      blk[j] = {hi_neg ? (j >= 16) : (j < 16), 5'(j % 16 + 8), 10'b0};
  endtask

  task automatic check_pattern(input bit hi_neg, input string tag);
    int bad;
    bad = 0;
    for (int j = 0; j < 32; j++) if (got[8*j +: 8] !== pat_code(j, hi_neg)) bad = j + 1;
    check8({tag, " lane order"}, 8'(bad), 8'd0);
    check8({tag, " pattern scale"}, gsc, 8'h7F);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      errors++;
      $display("FAIL R1 watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check8("R10 reset out_valid", {7'b0, out_valid}, 8'd0);
    check8("R10 reset in_ready", {7'b0, in_ready}, 8'd1);
    rst_n = 1'b1;
    @(negedge clk);

    for (int r = 0; r < 15; r++) begin
      for (int j = 0; j < 32; j++) blk[j] = 16'h0000;
      blk[13] = VEC[r][63:48];
      blk[int'(VEC[r][31:24])] = VEC[r][47:32];
      send_block();
      get_block();
      check8({VTAG[r], " scale"}, gsc, VEC[r][23:16]);
      check8({VTAG[r], " code x"}, got[8*13 +: 8], VEC[r][15:8]);
      check8({VTAG[r], " code amax"}, got[8*int'(VEC[r][31:24]) +: 8], VEC[r][7:0]);
      for (int j = 0; j < 32; j++)
        if (j != 13 && j != int'(VEC[r][31:24]))
          check8("R8 zero element", got[8*j +: 8], 8'h00);
    end

    // R1: lane order and output timing
    out_ready = 1'b1;
    fill_pattern(1'b1);
    send_block();
    check8("R1 not valid before next edge", {7'b0, out_valid}, 8'd0);
    @(negedge clk);
    check8("R1 valid one cycle later", {7'b0, out_valid}, 8'd1);
    got = out_codes;
    gsc = out_scale;
    check_pattern(1'b1, "R1");
    @(negedge clk);

    // R9: backpressure and hold
    out_ready = 1'b0;
    fill_pattern(1'b1);
    send_block();
    fill_pattern(1'b0);
    send_block();
    check8("R9 in_ready low when both full", {7'b0, in_ready}, 8'd0);
    got = out_codes;
    repeat (3) @(negedge clk);
    check8("R9 held valid", {7'b0, out_valid}, 8'd1);
    check8("R9 held codes", 8'(got != out_codes), 8'd0);
    check8("R9 still stalled", {7'b0, in_ready}, 8'd0);
    get_block();
    check_pattern(1'b1, "R9 first");
    get_block();
    check_pattern(1'b0, "R9 second");

    // R10: reset mid-group discards the partial group
    out_ready = 1'b0;
    in_valid = 1'b1;
    in_data = {8{16'h7C00}};
    @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check8("R10 mid reset valid", {7'b0, out_valid}, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int j = 0; j < 32; j++) blk[j] = 16'h0000;
    blk[0]  = 16'h5F00;
    blk[13] = 16'h3C00;
    send_block();
    get_block();
    check8("R10 fresh group scale", gsc, 8'h7F);
    check8("R10 fresh group code", got[8*13 +: 8], 8'h38);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule